// File: doc/BRIEF.md
# Streaming 3x3 Convolution with Carried Row Partial Sums

This block applies a two-dimensional convolution to a raster pixel stream at one pixel per clock. It treats the kernel rows as separate one-dimensional horizontal filters. Every incoming line is passed through all of these row filters at the same time. One row-filter result completes the output pixel for the current line. The others are added into partial-sum line buffers that are read back while the next line streams in. Each raw pixel is used only while it is current, and it is never fetched again for a later line.

A frame is sent as consecutive lines of equal width, with `in_sof` and `in_sol` flagging the first pixel of the frame and of each line. Coefficients are written one at a time through a small load port, normally between frames. The wide result is scaled by a programmable right shift and clamped to the pixel range before it leaves the block.

Top module: `f2d_stream_conv`

## Requirements
- R1: A pixel is taken on every clock edge where `in_valid` is high, with no back-pressure. An emitted result for the pixel taken at edge t appears on `out_pix`, with `out_valid` high, right after edge t+2. `out_pix` holds its value while `out_valid` is low.
- R2: For line r (counting from 0 at `in_sof`) and column c (counting from 0 at `in_sol`), the output is the sum over i,j in 0..2 of k[i][j]·x[r-2+i][c-2+j]. Here row index i=0 is the oldest of the three lines and column index j=0 is the oldest of the three columns. Pixels are unsigned and coefficients are signed.
- R3: Columns to the left of column 0 count as zero pixels, so column 0 and column 1 of each line see zero padding.
- R4: Lines 0 and 1 of a frame produce no output. Every later line produces exactly one output per input pixel. `in_sof` is given together with `in_sol` on the first pixel of a frame, and the first pixel after reset carries `in_sof`.
- R5: Idle cycles (`in_valid` low) anywhere inside a line or between lines do not change any result.
- R6: The sum is shifted arithmetically right by `shift_amt` bits. The shifted value is then clamped to 0 when negative and to 4095 when above 4095.
- R7: With `coef_we` high at an edge, `coef_data` (8-bit two's complement) becomes k[`coef_row`][`coef_col`]. The new value applies to pixels taken after that edge. Reset sets all coefficients to zero, which makes every output 0.
- R8: During reset `out_valid` is low.
- R9: Line width may be any value from 2 up to the buffer depth of 1024. All lines within a frame have the same width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame (given with in_sol) |
| in_sol | input | 1 | First pixel of a line |
| in_pix | input | 12 | Unsigned input pixel |
| coef_we | input | 1 | Coefficient write strobe |
| coef_row | input | 2 | Kernel row index (0 = oldest line) |
| coef_col | input | 2 | Kernel column index (0 = oldest column) |
| coef_data | input | 8 | Signed coefficient value |
| shift_amt | input | 5 | Right shift applied to the sum |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 12 | Scaled, clamped output pixel |

## Verification
The hardest state to reach from the ports is one where a partial sum has crossed two lines while the stream stalls at random points. A stall in the middle of a line must not move the read or write address of the buffer. The bench gets there by inserting random idle cycles inside lines, on a frame whose coefficients and pixels are all random. Directed frames cover the two-pixel-wide line, where buffer reads and writes sit on adjacent addresses. They also cover kernels that pick out the clamp limits and the left padding columns.

// File: rtl/f2d_pkg.sv
`timescale 1ns/1ps
package f2d_pkg;
  // Width of a sum of `taps` products of an unsigned pixel and a signed coefficient.
  function automatic int acc_width(input int pix_w, input int coef_w, input int taps);
    return pix_w + 1 + coef_w + $clog2(taps);
  endfunction
endpackage

// File: rtl/f2d_row_filter.sv
`timescale 1ns/1ps
module f2d_row_filter #(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 8,
  parameter int KC     = 3,
  parameter int ACC_W  = 25
) (
  input  logic [KC*PIX_W-1:0]     taps_i,
  input  logic [KC*COEF_W-1:0]    coef_i,
  output logic signed [ACC_W-1:0] sum_o
);
  localparam int PXPAD = ACC_W - PIX_W;
  localparam int CFPAD = ACC_W - COEF_W;

  always_comb begin
    logic signed [ACC_W-1:0] px;
    logic signed [ACC_W-1:0] cf;
    sum_o = '0;
    for (int j = 0; j < KC; j++) begin
      px = $signed({{PXPAD{1'b0}}, taps_i[j*PIX_W +: PIX_W]});
      cf = $signed({{CFPAD{coef_i[j*COEF_W+COEF_W-1]}}, coef_i[j*COEF_W +: COEF_W]});
      sum_o = sum_o + px * cf;
    end
  end
endmodule

// File: rtl/f2d_line_ram.sv
`timescale 1ns/1ps
module f2d_line_ram #(
  parameter int DATA_W = 25,
  parameter int DEPTH  = 1024,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/f2d_out_stage.sv
`timescale 1ns/1ps
module f2d_out_stage #(
  parameter int ACC_W = 25,
  parameter int PIX_W = 12,
  parameter int SH_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v_i,
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [SH_W-1:0]         shift_i,
  output logic                    out_valid_o,
  output logic [PIX_W-1:0]        out_pix_o
);
  localparam logic signed [ACC_W-1:0] PIX_MAX = {{(ACC_W-PIX_W){1'b0}}, {PIX_W{1'b1}}};

  logic signed [ACC_W-1:0] shd;
  logic [PIX_W-1:0]        clamped;

  always_comb begin
    shd = acc_i >>> shift_i;
    if (shd < 0)            clamped = '0;
    else if (shd > PIX_MAX) clamped = {PIX_W{1'b1}};
    else                    clamped = shd[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
    end else begin
      out_valid_o <= v_i;
      if (v_i) out_pix_o <= clamped;
    end
  end

  AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (v_i && acc_i < 0) |=> (out_pix_o == '0));  // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !v_i |=> $stable(out_pix_o));  // R1
endmodule

// File: rtl/f2d_stream_conv.sv
`timescale 1ns/1ps
module f2d_stream_conv #(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 8,
  parameter int KR     = 3,
  parameter int KC     = 3,
  parameter int MAX_W  = 1024,
  parameter int SH_W   = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic                   in_sol,
  input  logic [PIX_W-1:0]       in_pix,
  input  logic                   coef_we,
  input  logic [$clog2(KR)-1:0]  coef_row,
  input  logic [$clog2(KC)-1:0]  coef_col,
  input  logic [COEF_W-1:0]      coef_data,
  input  logic [SH_W-1:0]        shift_amt,
  output logic                   out_valid,
  output logic [PIX_W-1:0]       out_pix
);
  localparam int ACC_W = f2d_pkg::acc_width(PIX_W, COEF_W, KR * KC);
  localparam int COL_W = $clog2(MAX_W);
  localparam int LC_W  = $clog2(KR) + 1;
  localparam int NBUF  = KR - 1;

  // Coefficient store
  logic [COEF_W-1:0] coef_q [KR][KC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < KR; i++)
        for (int j = 0; j < KC; j++)
          coef_q[i][j] <= '0;
    end else if (coef_we && (int'(coef_row) < KR) && (int'(coef_col) < KC)) begin
      coef_q[coef_row][coef_col] <= coef_data;
    end
  end

  // Input stage: column / line position and horizontal window
  logic [COL_W-1:0] col_q, col_now, a_col;
  logic [LC_W-1:0]  line_q, line_now;
  logic             emit_now, a_valid, a_emit;
  logic [PIX_W-1:0] win_q [KC];

  always_comb begin
    col_now = in_sol ? '0 : col_q + COL_W'(1);
    if (in_sof)
      line_now = '0;
    else if (in_sol && line_q != LC_W'(KR-1))
      line_now = line_q + LC_W'(1);
    else
      line_now = line_q;
    emit_now = (line_now == LC_W'(KR-1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q   <= '0;
      line_q  <= '0;
      a_valid <= 1'b0;
      a_emit  <= 1'b0;
      a_col   <= '0;
      for (int j = 0; j < KC; j++) win_q[j] <= '0;
    end else begin
      a_valid <= in_valid;
      if (in_valid) begin
        col_q  <= col_now;
        line_q <= line_now;
        a_emit <= emit_now;
        a_col  <= col_now;
        for (int j = 0; j < KC-1; j++) win_q[j] <= in_sol ? '0 : win_q[j+1];
        win_q[KC-1] <= in_pix;
      end
    end
  end

  // Row filters, all rows in parallel on the same window
  logic [KC*PIX_W-1:0]     taps_flat;
  logic signed [ACC_W-1:0] row_sum [KR];

  for (genvar j = 0; j < KC; j++) begin : g_taps
    assign taps_flat[j*PIX_W +: PIX_W] = win_q[j];
  end

  for (genvar i = 0; i < KR; i++) begin : g_row
    logic [KC*COEF_W-1:0] cflat;
    for (genvar j = 0; j < KC; j++) begin : g_cf
      assign cflat[j*COEF_W +: COEF_W] = coef_q[i][j];
    end
    f2d_row_filter #(
      .PIX_W(PIX_W), .COEF_W(COEF_W), .KC(KC), .ACC_W(ACC_W)
    ) u_rf (
      .taps_i(taps_flat),
      .coef_i(cflat),
      .sum_o (row_sum[i])
    );
  end

  // Partial-sum line buffers: buffer d holds the sum for the output line d+1 ahead
  logic [ACC_W-1:0] ps_rd [NBUF];
  logic [ACC_W-1:0] ps_wr [NBUF];

  for (genvar d = 0; d < NBUF; d++) begin : g_buf
    if (d == NBUF-1) begin : g_first
      assign ps_wr[d] = row_sum[KR-2-d];
    end else begin : g_chain
      assign ps_wr[d] = ps_rd[d+1] + row_sum[KR-2-d];
    end
    f2d_line_ram #(
      .DATA_W(ACC_W), .DEPTH(MAX_W), .AW(COL_W)
    ) u_ram (
      .clk  (clk),
      .we   (a_valid),
      .waddr(a_col),
      .wdata(ps_wr[d]),
      .re   (in_valid),
      .raddr(col_now),
      .rdata(ps_rd[d])
    );
  end

  // Completion stage
  logic                    b_valid;
  logic signed [ACC_W-1:0] b_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid <= 1'b0;
      b_acc   <= '0;
    end else begin
      b_valid <= a_valid && a_emit;
      if (a_valid) b_acc <= $signed(ps_rd[0]) + row_sum[KR-1];
    end
  end

  f2d_out_stage #(
    .ACC_W(ACC_W), .PIX_W(PIX_W), .SH_W(SH_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .v_i        (b_valid),
    .acc_i      (b_acc),
    .shift_i    (shift_amt),
    .out_valid_o(out_valid),
    .out_pix_o  (out_pix)
  );

  // Checks
  logic pad_clear;
  always_comb begin
    pad_clear = 1'b1;
    for (int j = 0; j < KC-1; j++)
      if (win_q[j] != '0) pad_clear = 1'b0;
  end

  AST_PAD_LEFT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sol) |=> pad_clear);  // R3
  AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));  // R1
  AST_FIRST_LINES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> !a_emit);  // R4
  AST_LINE_MIN: assert property (@(posedge clk) disable iff (rst)
    (a_valid && in_valid) |-> (col_now != a_col));  // R9
  AST_LINE_MAX: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sol) |-> (col_q != COL_W'(MAX_W-1)));  // R9
endmodule

// File: tb/f2d_stream_conv_tb.sv
`timescale 1ns/1ps
module f2d_stream_conv_tb_top;
  localparam int MW = 64;
  localparam int MH = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_sof, in_sol;
  logic [11:0] in_pix;
  logic       coef_we;
  logic [1:0] coef_row, coef_col;
  logic [7:0] coef_data;
  logic [4:0] shift_amt;
  logic       out_valid;
  logic [11:0] out_pix;

  always #4 clk = ~clk;

  f2d_stream_conv dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol), .in_pix(in_pix),
    .coef_we(coef_we), .coef_row(coef_row), .coef_col(coef_col), .coef_data(coef_data),
    .shift_amt(shift_amt),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int got    = 0;
  int img [MH][MW];
  int kb [3][3];
  int sh_b = 0;
  int exp_q[$];
  int stamp_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expd);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expd);
    end
  endtask

  function automatic int expv(input int r, input int c);
    int acc = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        if (c - 2 + j >= 0) acc += kb[i][j] * img[r-2+i][c-2+j];
    acc = acc >>> sh_b;
    if (acc < 0) acc = 0;
    if (acc > 4095) acc = 4095;
    return acc;
  endfunction

  // Output monitor
  always @(negedge clk) begin
    int e, st;
    string t;
    if (!rst && out_valid) begin
      got++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected output", int'(out_pix), -1);
      end else begin
        e  = exp_q.pop_front();
        st = stamp_q.pop_front();
        t  = tag_q.pop_front();
        check(int'(out_pix) == e, t, "pixel value", int'(out_pix), e);
        check(cyc == st + 2, "R1", "latency", cyc - st, 2);
      end
    end
  end

  task automatic set_coef(input int i, input int j, input int v);
    @(negedge clk);
    in_valid  = 1'b0;
    coef_we   = 1'b1;
    coef_row  = 2'(i);
    coef_col  = 2'(j);
    coef_data = 8'(v);
    kb[i][j]  = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic set_shift(input int v);
    @(negedge clk);
    shift_amt = 5'(v);
    sh_b      = v;
  endtask

  task automatic fill_rand(input int w, input int h);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        img[r][c] = $urandom_range(0, 4095);
  endtask

  task automatic run_frame(input int w, input int h, input bit gaps, input string tag);
    got = 0;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        if (gaps && $urandom_range(0, 3) == 0) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_sol   = 1'b0;
          in_sof   = 1'b0;
        end
        @(negedge clk);
        coef_we  = 1'b0;
        in_valid = 1'b1;
        in_pix   = img[r][c][11:0];
        in_sol   = (c == 0);
        in_sof   = (r == 0 && c == 0);
        if (r >= 2) begin
          exp_q.push_back(expv(r, c));
          stamp_q.push_back(cyc + 1);
          tag_q.push_back(tag);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sol   = 1'b0;
    in_sof   = 1'b0;
    repeat (6) @(negedge clk);
    check(got == (h - 2) * w, "R4", "output count", got, (h - 2) * w);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0; in_pix = '0;
    coef_we = 1'b0; coef_row = '0; coef_col = '0; coef_data = '0; shift_amt = '0;
    for (int i = 0; i < 3; i++) for (int j = 0; j < 3; j++) kb[i][j] = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid during reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);

    // R7: coefficients cleared by reset give all-zero outputs
    fill_rand(10, 4);
    run_frame(10, 4, 1'b0, "R7");

    // R2: single tap on newest line, newest column passes the pixel through
    set_coef(2, 2, 1);
    fill_rand(16, 5);
    run_frame(16, 5, 1'b0, "R2");

    // R5: random kernel with idle gaps inside and between lines
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        set_coef(i, j, int'($urandom_range(0, 255)) - 128);
    set_shift(8);
    fill_rand(40, 6);
    run_frame(40, 6, 1'b1, "R5");

    // R2: random kernel, full width frame, back to back lines
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        set_coef(i, j, int'($urandom_range(0, 255)) - 128);
    set_shift(6);
    fill_rand(MW, MH);
    run_frame(MW, MH, 1'b0, "R2");

    // R6: upper clamp
    for (int i = 0; i < 3; i++) for (int j = 0; j < 3; j++) set_coef(i, j, 127);
    set_shift(0);
    for (int r = 0; r < 4; r++) for (int c = 0; c < 8; c++) img[r][c] = 4095;
    run_frame(8, 4, 1'b0, "R6");

    // R6: lower clamp
    for (int i = 0; i < 3; i++) for (int j = 0; j < 3; j++) set_coef(i, j, -128);
    fill_rand(8, 4);
    run_frame(8, 4, 1'b0, "R6");

    // R3: only the oldest column is weighted, so columns 0 and 1 see padding
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        set_coef(i, j, (j == 0) ? 1 : 0);
    fill_rand(12, 4);
    run_frame(12, 4, 1'b0, "R3");

    // R9: narrowest line width
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        set_coef(i, j, int'($urandom_range(0, 255)) - 128);
    set_shift(7);
    fill_rand(2, 6);
    run_frame(2, 6, 1'b0, "R9");

    check(exp_q.size() == 0, "R4", "leftover expected outputs", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule